// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block holds a 32-bit word of pending interrupt causes and turns it into a request toward a host. Two internal event sources, a factorial-done pulse and a DMA-done pulse, each own one fixed bit of the word. Software can set any bits through a set strobe with a mask, and can acknowledge (clear) bits through a clear strobe with a mask. The current word is always visible on a read output.

The request leaves the block in one of two forms, chosen by an MSI-enable input. With MSI off, a level output stays high while causes are pending. With MSI on, every set operation that leaves the word nonzero produces a one-clock notification pulse. This holds even when the bits being set were already pending, so a host sees a fresh message for each raise. The level output is pulled low only by an acknowledge that empties the word while MSI is off. If causes are acknowledged with MSI on, the level keeps its old value.

All results are registered: every input cycle is reflected on the outputs after the next rising clock edge.

Top module: `irq_status_agg`

## Requirements
- R1: A synchronous active-low reset drives the status word to 0, the level output low and the pulse output low.
- R2: A set operation ORs its mask into the status word; the new word is visible one clock after the strobe.
- R3: A clear operation removes its mask bits from the status word (word AND NOT mask), visible one clock after the strobe.
- R4: A factorial-done pulse sets status bit 0 and a DMA-done pulse sets status bit 8, each counting as a raise.
- R5: When a set and a clear name the same bit in the same cycle, the bit ends up set.
- R6: With MSI enabled, each raise that leaves the word nonzero gives exactly one one-clock pulse, even if every raised bit was already set; cycles with no raise give no pulse.
- R7: With MSI disabled, a raise that leaves the word nonzero drives the level output high.
- R8: The level output goes low only when a clear leaves the word zero while MSI is disabled; otherwise it holds, including when the word is emptied with MSI enabled.
- R9: A raise that leaves the word zero (set strobe with an empty mask) gives no pulse and does not change the level output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_set_i | input | 1 | Software set strobe |
| sw_set_mask_i | input | 32 | Bits to set |
| sw_clr_i | input | 1 | Software acknowledge strobe |
| sw_clr_mask_i | input | 32 | Bits to clear |
| fact_done_i | input | 1 | Factorial-done event (bit 0) |
| dma_done_i | input | 1 | DMA-done event (bit 8) |
| msi_en_i | input | 1 | Selects message pulse (1) or level (0) signalling |
| status_o | output | 32 | Current status word |
| legacy_irq_o | output | 1 | Level interrupt request |
| msi_pulse_o | output | 1 | One-clock message interrupt request |

## Verification
Every output of this block is due exactly one clock after the input cycle that causes it: status word, level and pulse are all registered from the same next-state value. The bench applies stimulus on the falling edge and computes the expected status, level and pulse for that cycle from its own model. It queues them and compares shortly after the following rising edge, so each comparison lines up with the single register stage. Idle cycles are queued too, which checks that a pulse never lasts beyond its one cycle.

// File: rtl/irq_agg_pkg.sv
// Package: shared widths, source bit positions and the per-cycle operation record
// used by the interrupt status aggregator. Assumes a 32-bit status word by default.
package irq_agg_pkg;

    localparam int unsigned STAT_W_DEF   = 32;
    localparam int unsigned FACT_BIT_DEF = 0;
    localparam int unsigned DMA_BIT_DEF  = 8;

    // One cycle's decoded operation: whether any raise or lower happened.
    typedef struct packed {
        logic raise;
        logic lower;
    } agg_op_t;

endpackage

// File: rtl/irq_src_merge.sv
// Module: irq_src_merge
// Merges the software set mask with the two internal event sources into one
// set mask, gates the clear mask by its strobe, and reports whether this cycle
// is a raise and/or a lower. Assumes the source bit positions lie inside W.
module irq_src_merge
    import irq_agg_pkg::*;
#(
    parameter int unsigned W        = STAT_W_DEF,
    parameter int unsigned FACT_BIT = FACT_BIT_DEF,
    parameter int unsigned DMA_BIT  = DMA_BIT_DEF
) (
    input  logic         sw_set_i,
    input  logic [W-1:0] sw_set_mask_i,
    input  logic         sw_clr_i,
    input  logic [W-1:0] sw_clr_mask_i,
    input  logic         fact_done_i,
    input  logic         dma_done_i,
    output logic [W-1:0] set_mask_o,
    output logic [W-1:0] clr_mask_o,
    output agg_op_t      op_o
);

    // Per bit: software set, plus an internal source if this bit belongs to one.
    for (genvar b = 0; b < W; b++) begin : g_bit
        localparam bit IS_FACT = (b == FACT_BIT);
        localparam bit IS_DMA  = (b == DMA_BIT);
        always_comb begin
            set_mask_o[b] = (sw_set_i & sw_set_mask_i[b])
                          | (IS_FACT & fact_done_i)
                          | (IS_DMA & dma_done_i);
            clr_mask_o[b] = sw_clr_i & sw_clr_mask_i[b];
        end
    end

    // Classify the cycle: any source or software set is a raise.
    always_comb begin
        op_o.raise = sw_set_i | fact_done_i | dma_done_i;
        op_o.lower = sw_clr_i;
    end

endmodule

// File: rtl/irq_status_reg.sv
// Module: irq_status_reg
// Holds the status word. Next value is (word & ~clear) | set, so a set wins
// over a clear of the same bit. Exposes the next value for the notifier.
module irq_status_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_mask_i,
    input  logic [W-1:0] clr_mask_i,
    output logic [W-1:0] status_d_o,
    output logic         next_nz_o,
    output logic [W-1:0] status_q_o
);

    // Next-state: clear first, then OR in the set mask.
    always_comb begin
        status_d_o = (status_q_o & ~clr_mask_i) | set_mask_i;
        next_nz_o  = |status_d_o;
    end

    // Status register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q_o <= '0;
        else        status_q_o <= status_d_o;
    end

endmodule

// File: rtl/irq_notify.sv
// Module: irq_notify
// Produces the level request and the one-clock message pulse from the
// operation of the cycle and whether the next status word is nonzero.
// Assumes msi_en_i is stable around the operations it governs.
module irq_notify
    import irq_agg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  agg_op_t op_i,
    input  logic    next_nz_i,
    input  logic    msi_en_i,
    output logic    legacy_o,
    output logic    pulse_o
);

    logic raise_nz;
    logic legacy_d;
    logic pulse_d;

    // Decide the next level and pulse values.
    always_comb begin
        raise_nz = op_i.raise & next_nz_i;
        pulse_d  = raise_nz & msi_en_i;
        legacy_d = legacy_o;
        if (raise_nz && !msi_en_i)
            legacy_d = 1'b1;
        else if (op_i.lower && !next_nz_i && !msi_en_i)
            legacy_d = 1'b0;
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_o <= 1'b0;
            pulse_o  <= 1'b0;
        end else begin
            legacy_o <= legacy_d;
            pulse_o  <= pulse_d;
        end
    end

endmodule

// File: rtl/irq_status_agg.sv
// Module: irq_status_agg (top)
// Interrupt status aggregator: merges sources into a status word and signals
// it as a level or a message pulse. All outputs are registered, one clock
// after the causing input cycle. Assumes a single clock domain.
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned STAT_W   = STAT_W_DEF,
    parameter int unsigned FACT_BIT = FACT_BIT_DEF,
    parameter int unsigned DMA_BIT  = DMA_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_set_i,
    input  logic [STAT_W-1:0] sw_set_mask_i,
    input  logic              sw_clr_i,
    input  logic [STAT_W-1:0] sw_clr_mask_i,
    input  logic              fact_done_i,
    input  logic              dma_done_i,
    input  logic              msi_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              legacy_irq_o,
    output logic              msi_pulse_o
);

    logic [STAT_W-1:0] set_mask;
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] status_d;
    logic              next_nz;
    agg_op_t           op;

    irq_src_merge #(.W(STAT_W), .FACT_BIT(FACT_BIT), .DMA_BIT(DMA_BIT)) u_merge (
        .sw_set_i      (sw_set_i),
        .sw_set_mask_i (sw_set_mask_i),
        .sw_clr_i      (sw_clr_i),
        .sw_clr_mask_i (sw_clr_mask_i),
        .fact_done_i   (fact_done_i),
        .dma_done_i    (dma_done_i),
        .set_mask_o    (set_mask),
        .clr_mask_o    (clr_mask),
        .op_o          (op)
    );

    irq_status_reg #(.W(STAT_W)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_mask_i (set_mask),
        .clr_mask_i (clr_mask),
        .status_d_o (status_d),
        .next_nz_o  (next_nz),
        .status_q_o (status_o)
    );

    irq_notify u_notify (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (op),
        .next_nz_i (next_nz),
        .msi_en_i  (msi_en_i),
        .legacy_o  (legacy_irq_o),
        .pulse_o   (msi_pulse_o)
    );

endmodule

// File: rtl/irq_status_agg_chk.sv
// Module: irq_status_agg_chk
// Checker bound to irq_status_agg: relates the ports over one clock.
module irq_status_agg_chk #(
    parameter int unsigned STAT_W   = 32,
    parameter int unsigned FACT_BIT = 0,
    parameter int unsigned DMA_BIT  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_set_i,
    input logic [STAT_W-1:0] sw_set_mask_i,
    input logic              sw_clr_i,
    input logic [STAT_W-1:0] sw_clr_mask_i,
    input logic              fact_done_i,
    input logic              dma_done_i,
    input logic              msi_en_i,
    input logic [STAT_W-1:0] status_o,
    input logic              legacy_irq_o,
    input logic              msi_pulse_o
);

    // R5
    set_bits_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_set_i |=> ((status_o & $past(sw_set_mask_i)) == $past(sw_set_mask_i)));

    // R4
    src_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fact_done_i && dma_done_i) |=> (status_o[FACT_BIT] && status_o[DMA_BIT]));

    // R6
    no_pulse_without_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en_i |=> !msi_pulse_o);

    // R9
    pulse_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse_o |-> (status_o != '0));

    // R8
    level_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (legacy_irq_o && msi_en_i) |=> legacy_irq_o);

    // R7
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(legacy_irq_o) |-> (status_o != '0));

    // R3
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && !sw_set_i && !fact_done_i && !dma_done_i)
            |=> ((status_o & $past(sw_clr_mask_i)) == '0));

endmodule

bind irq_status_agg irq_status_agg_chk #(
    .STAT_W(STAT_W), .FACT_BIT(FACT_BIT), .DMA_BIT(DMA_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_set_i      (sw_set_i),
    .sw_set_mask_i (sw_set_mask_i),
    .sw_clr_i      (sw_clr_i),
    .sw_clr_mask_i (sw_clr_mask_i),
    .fact_done_i   (fact_done_i),
    .dma_done_i    (dma_done_i),
    .msi_en_i      (msi_en_i),
    .status_o      (status_o),
    .legacy_irq_o  (legacy_irq_o),
    .msi_pulse_o   (msi_pulse_o)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;

    typedef struct {
        logic [31:0] st;
        logic        leg;
        logic        pls;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_set = 1'b0;
    logic [31:0] sw_set_mask = '0;
    logic        sw_clr = 1'b0;
    logic [31:0] sw_clr_mask = '0;
    logic        fact = 1'b0;
    logic        dma = 1'b0;
    logic        msi = 1'b0;
    logic [31:0] status;
    logic        legacy;
    logic        pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    exp_t        sb[$];
    logic [31:0] m_st  = '0;
    logic        m_leg = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_agg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_set_i      (sw_set),
        .sw_set_mask_i (sw_set_mask),
        .sw_clr_i      (sw_clr),
        .sw_clr_mask_i (sw_clr_mask),
        .fact_done_i   (fact),
        .dma_done_i    (dma),
        .msi_en_i      (msi),
        .status_o      (status),
        .legacy_irq_o  (legacy),
        .msi_pulse_o   (pulse)
    );

    // Driver: apply one cycle of stimulus, model it, push the expectation.
    task automatic drive(input logic rn, input logic s, input logic [31:0] sm,
                         input logic c, input logic [31:0] cm,
                         input logic f, input logic d, input logic me,
                         input string tag);
        logic [31:0] setm;
        logic [31:0] nxt;
        logic        raise;
        logic        p;
        exp_t        e;
        @(negedge clk);
        rst_n = rn; sw_set = s; sw_set_mask = sm; sw_clr = c; sw_clr_mask = cm;
        fact = f; dma = d; msi = me;
        setm  = (s ? sm : 32'h0) | (f ? 32'h1 : 32'h0) | (d ? 32'h100 : 32'h0);
        raise = s | f | d;
        nxt   = (m_st & ~(c ? cm : 32'h0)) | setm;
        p     = 1'b0;
        if (!rn) begin
            m_st = '0; m_leg = 1'b0;
        end else begin
            p = raise && (nxt != 0) && me;
            if (raise && nxt != 0 && !me)     m_leg = 1'b1;
            else if (c && nxt == 0 && !me)   m_leg = 1'b0;
            m_st = nxt;
        end
        e.st = m_st; e.leg = m_leg; e.pls = p; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input logic me, input string tag);
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, me, tag);
    endtask

    task automatic check1(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: one register stage, so compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check1(e.tag, "status", status, e.st);
                check1(e.tag, "legacy", {31'b0, legacy}, {31'b0, e.leg});
                check1(e.tag, "msi",    {31'b0, pulse},  {31'b0, e.pls});
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        drive(1'b0, 1'b1, 32'hFFFF, 1'b0, '0, 1'b1, 1'b1, 1'b0, "R1");
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1");
        // R2 / R7: set with MSI off raises level
        drive(1'b1, 1'b1, 32'h5, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2_R7");
        // R3 / R8: partial clear keeps level
        drive(1'b1, 1'b0, '0, 1'b1, 32'h1, 1'b0, 1'b0, 1'b0, "R3_R8");
        // R8: clear to zero drops level
        drive(1'b1, 1'b0, '0, 1'b1, 32'h4, 1'b0, 1'b0, 1'b0, "R8");
        // R4: internal sources at bits 0 and 8
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R4");
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R4");
        // R5: set wins on overlap
        drive(1'b1, 1'b1, 32'hF0, 1'b1, 32'hF1, 1'b0, 1'b0, 1'b0, "R5");
        drive(1'b1, 1'b0, '0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R3");
        // R6: MSI pulses, repeated on already-set bit
        drive(1'b1, 1'b1, 32'h2, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R6");
        idle(1'b1, "R6");
        drive(1'b1, 1'b1, 32'h2, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R6");
        drive(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b1, "R6");
        drive(1'b1, 1'b0, '0, 1'b1, 32'h3, 1'b0, 1'b0, 1'b1, "R6");
        // R8: level held when emptied with MSI on, dropped later with MSI off
        drive(1'b1, 1'b1, 32'h8, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
        drive(1'b1, 1'b0, '0, 1'b1, 32'h8, 1'b0, 1'b0, 1'b1, "R8");
        idle(1'b1, "R8");
        drive(1'b1, 1'b0, '0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, "R8");
        // R9: empty-mask raise does nothing
        drive(1'b1, 1'b1, 32'h0, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R9");
        drive(1'b1, 1'b1, 32'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");
        // R1: reset mid-run clears everything
        drive(1'b1, 1'b1, 32'hFF, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
        drive(1'b0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1");
        idle(1'b0, "R1");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule